// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block sits beside the access controller of a DRAM-cell memory that has an asynchronous SRAM interface. It drives the memory's active-high second chip enable and forces the active-low primary chip enable to its inactive (high) level whenever the memory is not open for accesses. Once the supply-good input is seen high, the block runs the start-up sequence. The second enable is held low for a minimum time. Then it is raised while the primary enable is still forced high, and that condition is held for a long settling time. Only after that does the block grant accesses.

While accesses are granted, the host can ask for deep power-down with a one-cycle request. If the access controller reports that it is busy, the request is kept until the controller goes idle. Entry keeps the second enable high for a short setup time after the primary enable has been forced high. The second enable then drops and is held low for a minimum time. A wake request raises it again, and the long settling time is served once more before accesses are granted. A drop of the supply-good input aborts every sequence. The data bus is kept in high impedance whenever accesses are not granted.

All intervals are parameters counted in clock cycles. The defaults assume a 200 MHz clock: 50 µs low hold, 350 µs settle, 10 ns entry setup and 70 ns minimum power-down.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, or after reset while supply_ok is low, the outputs are ce2=0, ce1_force=1, acc_grant=0 and dq_hiz=1.
- R2: When supply_ok is first sampled high, ce2 stays low for exactly C2_LOW_CYC further clock edges and rises at the next edge after those.
- R3: Every rising edge of ce2 happens while ce1_force is already high and stays high.
- R4: After ce2 rises, acc_grant goes high exactly C1_HIGH_CYC clock edges later. This holds after power-up and after a wake from power-down.
- R5: acc_grant is high only when the block is in standby. In that state ce2=1, ce1_force=0 and dq_hiz=0.
- R6: A pd_req pulse sampled in standby with acc_busy low drops acc_grant at the next edge. ce2 then stays high with ce1_force high for PD_SETUP_CYC edges before it falls.
- R7: A pd_req sampled in standby while acc_busy is high is kept. Power-down begins at the first edge where acc_busy is sampled low.
- R8: A pd_req pulse that arrives when the block is not in standby is dropped and does not cause a later power-down.
- R9: In power-down, ce2 stays low for at least PD_HOLD_CYC edges. A wake_req that arrives earlier is kept and takes effect when that time ends.
- R10: A wake_req in power-down, once the hold time has passed, raises ce2 at the next edge with ce1_force high and acc_grant low.
- R11: A wake_req outside power-down has no effect and is not kept for a later power-down.
- R12: supply_ok sampled low in any state gives ce2=0 and acc_grant=0 after the next edge, and restarts the power-up sequence from the beginning.
- R13: dq_hiz is high throughout power-down and in every state where acc_grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Memory supply has reached its minimum level |
| pd_req | input | 1 | Host pulse asking for deep power-down |
| wake_req | input | 1 | Host pulse asking to leave deep power-down |
| acc_busy | input | 1 | Access controller has a cycle in progress |
| ce2 | output | 1 | Second chip enable to the memory, active high |
| ce1_force | output | 1 | Forces the primary chip enable to its inactive level |
| acc_grant | output | 1 | Access controller may run cycles |
| dq_hiz | output | 1 | Holds the data bus in high impedance |

## Verification
Two groups of events can meet on a single clock edge. The first is a host request and a state change: a wake pulse lands while the power-down hold is still running, a power-down pulse lands during the wake settling, and busy drops while a power-down is pending. The second is a supply loss and an ongoing sequence. The bench places each request on the edge just before, or inside, the interval under test. A behavioural model that keeps elapsed-time counters and pending flags then judges every cycle. Supply-good is also dropped during the settle phase, in power-down and in standby, to show that the abort wins over the timer.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int unsigned C2_LOW_CYC   = 10000,
  parameter int unsigned C1_HIGH_CYC  = 70000,
  parameter int unsigned PD_SETUP_CYC = 2,
  parameter int unsigned PD_HOLD_CYC  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pd_req,
  input  logic wake_req,
  input  logic acc_busy,
  output logic ce2,
  output logic ce1_force,
  output logic acc_grant,
  output logic dq_hiz
);

  localparam int unsigned MAX_A  = (C2_LOW_CYC > C1_HIGH_CYC) ? C2_LOW_CYC : C1_HIGH_CYC;
  localparam int unsigned MAX_B  = (PD_SETUP_CYC > PD_HOLD_CYC) ? PD_SETUP_CYC : PD_HOLD_CYC;
  localparam int unsigned MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] LIM_C2L = CW'(C2_LOW_CYC - 1);
  localparam logic [CW-1:0] LIM_C1H = CW'(C1_HIGH_CYC - 1);
  localparam logic [CW-1:0] LIM_PDS = CW'(PD_SETUP_CYC - 1);
  localparam logic [CW-1:0] LIM_PDH = CW'(PD_HOLD_CYC - 1);

  typedef enum logic [2:0] {
    WAIT_SUPPLY, C2_LOW_HOLD, C1_HIGH_HOLD, READY, PD_ENTRY, PD_ACTIVE, PD_EXIT
  } pstate_t;

  pstate_t       st, st_nx;
  logic [CW-1:0] cnt, lim;
  logic          pd_pend, wk_pend;
  logic          done, go_pd, go_wk;

  always_comb begin
    case (st)
      C2_LOW_HOLD:            lim = LIM_C2L;
      C1_HIGH_HOLD, PD_EXIT:  lim = LIM_C1H;
      PD_ENTRY:               lim = LIM_PDS;
      PD_ACTIVE:              lim = LIM_PDH;
      default:                lim = '0;
    endcase
  end

  assign done  = (cnt == lim);
  assign go_pd = (st == READY) && (pd_pend || pd_req) && !acc_busy;
  assign go_wk = (st == PD_ACTIVE) && done && (wk_pend || wake_req);

  always_comb begin
    st_nx = st;
    case (st)
      WAIT_SUPPLY:  st_nx = C2_LOW_HOLD;
      C2_LOW_HOLD:  if (done)  st_nx = C1_HIGH_HOLD;
      C1_HIGH_HOLD: if (done)  st_nx = READY;
      READY:        if (go_pd) st_nx = PD_ENTRY;
      PD_ENTRY:     if (done)  st_nx = PD_ACTIVE;
      PD_ACTIVE:    if (go_wk) st_nx = PD_EXIT;
      PD_EXIT:      if (done)  st_nx = READY;
      default:      st_nx = WAIT_SUPPLY;
    endcase
    if (!supply_ok) st_nx = WAIT_SUPPLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WAIT_SUPPLY;
      cnt     <= '0;
      pd_pend <= 1'b0;
      wk_pend <= 1'b0;
    end else begin
      st      <= st_nx;
      cnt     <= (st_nx != st) ? '0 : (done ? cnt : cnt + 1'b1);
      pd_pend <= supply_ok && (st == READY) && (pd_pend || pd_req) && !go_pd;
      wk_pend <= supply_ok && (st == PD_ACTIVE) && (wk_pend || wake_req) && !go_wk;
    end
  end

  assign ce2       = (st == C1_HIGH_HOLD) || (st == READY) || (st == PD_ENTRY) || (st == PD_EXIT);
  assign acc_grant = (st == READY);
  assign ce1_force = !acc_grant;
  assign dq_hiz    = !acc_grant;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int unsigned C2_LOW_CYC   = 10000,
  parameter int unsigned C1_HIGH_CYC  = 70000,
  parameter int unsigned PD_SETUP_CYC = 2,
  parameter int unsigned PD_HOLD_CYC  = 14
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic ce2,
  input logic ce1_force,
  input logic acc_grant,
  input logic dq_hiz
);

  localparam int unsigned MIN_LOW = (PD_HOLD_CYC < C2_LOW_CYC) ? PD_HOLD_CYC : C2_LOW_CYC;
  localparam int unsigned SAT     = 32'hFFFF_0000;

  int unsigned low_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= 0;
      hi_run  <= 0;
    end else begin
      low_run <= ce2 ? 0 : ((low_run < SAT) ? low_run + 1 : low_run);
      hi_run  <= (ce2 && ce1_force) ? ((hi_run < SAT) ? hi_run + 1 : hi_run) : 0;
    end
  end

  a_r12_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!ce2 && !acc_grant));

  a_r3_ce1_before_ce2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (ce1_force && $past(ce1_force)));

  a_r5_grant_levels: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> (ce2 && !ce1_force && !dq_hiz));

  a_r6_entry_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce2) && $past(supply_ok)) |-> $past(ce1_force));

  a_r13_bus_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !ce2 |-> (dq_hiz && !acc_grant));

  a_r9_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (low_run >= MIN_LOW));

  a_r4_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_grant) |-> (hi_run >= C1_HIGH_CYC));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .C2_LOW_CYC(C2_LOW_CYC), .C1_HIGH_CYC(C1_HIGH_CYC),
  .PD_SETUP_CYC(PD_SETUP_CYC), .PD_HOLD_CYC(PD_HOLD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce2(ce2),
  .ce1_force(ce1_force), .acc_grant(acc_grant), .dq_hiz(dq_hiz)
);

// File: tb/psram_pwr_seq_test.sv
`timescale 1ns/1ps
module psram_pwr_seq_test;

  localparam int TL = 20;
  localparam int TH = 30;
  localparam int TS = 3;
  localparam int TP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, pd_req = 1'b0, wake_req = 1'b0, acc_busy = 1'b0;
  logic ce2, ce1_force, acc_grant, dq_hiz;

  always #2.5 clk = ~clk;

  psram_pwr_seq #(.C2_LOW_CYC(TL), .C1_HIGH_CYC(TH), .PD_SETUP_CYC(TS), .PD_HOLD_CYC(TP)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req), .wake_req(wake_req),
    .acc_busy(acc_busy), .ce2(ce2), .ce1_force(ce1_force), .acc_grant(acc_grant), .dq_hiz(dq_hiz)
  );

  int    n_chk = 0, n_fail = 0;
  string cur = "R1";
  bit    cmp_on = 1'b0;

  // reference: phase 0 off, 1 low hold, 2 settle, 3 standby, 4 entry, 5 down, 6 wake settle
  int ph = 0, t = 0;
  bit pp = 0, wp = 0;

  always @(posedge clk) begin
    if (!rst_n || !supply_ok) begin
      ph = 0; t = 0; pp = 0; wp = 0;
    end else begin
      case (ph)
        0: begin ph = 1; t = 0; end
        1: if (t == TL-1) begin ph = 2; t = 0; end else t++;
        2: if (t == TH-1) begin ph = 3; t = 0; end else t++;
        3: begin
             if (pd_req) pp = 1;
             if (pp && !acc_busy) begin ph = 4; t = 0; pp = 0; end
           end
        4: if (t == TS-1) begin ph = 5; t = 0; end else t++;
        5: begin
             if (wake_req) wp = 1;
             if (t < TP-1) t++;
             else if (wp) begin ph = 6; t = 0; wp = 0; end
           end
        default: if (t == TH-1) begin ph = 3; t = 0; end else t++;
      endcase
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [3:0] e;
      e = {(ph == 2 || ph == 3 || ph == 4 || ph == 6), (ph != 3), (ph == 3), (ph != 3)};
      chk(cur, "model {ce2,ce1_force,grant,hiz}", int'({ce2, ce1_force, acc_grant, dq_hiz}), int'(e));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    tick(3);
    chk("R1", "reset outputs", int'({ce2, ce1_force, acc_grant, dq_hiz}), 4'b0101);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    tick(3);
    chk("R1", "supply low outputs", int'({ce2, ce1_force, acc_grant, dq_hiz}), 4'b0101);

    cur = "R2"; supply_ok = 1'b1;
    tick(TL);     chk("R2", "ce2 still low", int'(ce2), 0);
    tick(1);      chk("R2", "ce2 rises", int'(ce2), 1);
                  chk("R3", "ce1_force at ce2 rise", int'(ce1_force), 1);
    cur = "R4";
    tick(TH-1);   chk("R4", "grant before settle", int'(acc_grant), 0);
    tick(1);      chk("R4", "grant after settle", int'(acc_grant), 1);
                  chk("R5", "ce1_force in standby", int'(ce1_force), 0);

    cur = "R7"; acc_busy = 1'b1; pd_req = 1'b1;
    tick(1); pd_req = 1'b0;
    tick(5);      chk("R7", "grant kept while busy", int'(acc_grant), 1);
    acc_busy = 1'b0;
    tick(1);      chk("R7", "grant drops after idle", int'(acc_grant), 0);
    cur = "R6";
    tick(TS-1);   chk("R6", "ce2 high in entry setup", int'(ce2), 1);
                  chk("R6", "ce1_force in entry setup", int'(ce1_force), 1);
    tick(1);      chk("R6", "ce2 falls", int'(ce2), 0);
                  chk("R13", "bus hiz in power-down", int'(dq_hiz), 1);

    cur = "R9"; wake_req = 1'b1;
    tick(1); wake_req = 1'b0;
    tick(TP-2);   chk("R9", "ce2 held low", int'(ce2), 0);
    tick(1);      chk("R9", "early wake served", int'(ce2), 1);
                  chk("R10", "ce1_force on wake", int'(ce1_force), 1);
    cur = "R8"; pd_req = 1'b1;
    tick(1); pd_req = 1'b0;
    tick(TH-2);   chk("R10", "grant before settle", int'(acc_grant), 0);
    tick(1);      chk("R10", "grant after settle", int'(acc_grant), 1);
    tick(10);     chk("R8", "stray pd_req dropped", int'(acc_grant), 1);

    cur = "R11"; wake_req = 1'b1;
    tick(1); wake_req = 1'b0;
    tick(5);      chk("R11", "wake in standby no effect", int'({ce2, acc_grant}), 2'b11);
    pd_req = 1'b1;
    tick(1); pd_req = 1'b0;
                  chk("R6", "idle pd_req drops grant", int'(acc_grant), 0);
    tick(TS + TP + 10);
                  chk("R11", "stale wake not kept", int'(ce2), 0);
    cur = "R10"; wake_req = 1'b1;
    tick(1); wake_req = 1'b0;
                  chk("R10", "late wake raises ce2", int'({ce2, acc_grant}), 2'b10);
    tick(TH);     chk("R10", "grant after late wake", int'(acc_grant), 1);

    cur = "R12"; pd_req = 1'b1;
    tick(1); pd_req = 1'b0;
    tick(TS + 3); supply_ok = 1'b0;
    tick(1);      chk("R12", "loss in power-down", int'({ce2, ce1_force, acc_grant}), 3'b010);
    supply_ok = 1'b1;
    tick(TL + 6); chk("R12", "restart reaches settle", int'(ce2), 1);
    supply_ok = 1'b0;
    tick(1);      chk("R12", "loss in settle", int'(ce2), 0);
    supply_ok = 1'b1;
    tick(TL + 1); chk("R2", "ce2 after restart", int'(ce2), 1);
    tick(TH);     chk("R4", "grant after restart", int'(acc_grant), 1);
    supply_ok = 1'b0;
    tick(1);      chk("R12", "loss in standby", int'({ce2, acc_grant, dq_hiz}), 3'b001);
    tick(3);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule